// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block keeps the eight-bit status word of a serial flash device and decides, one clock at a time, whether each decoded request may run. A front end that has already parsed the serial stream presents one request per cycle: latch set, latch clear, status write (with its data byte and a flag saying that more than one data byte arrived), small-sector erase, sector erase, chip erase, program, power-down and wake. The controller also takes the level of the write-protect pin. It grants or refuses each request. It compares the target address against the region chosen by the protect bits. For the self-timed operations it holds a busy bit high for a set number of clocks, and it clears the write-enable latch when the operation finishes.

The status word is laid out as {lock, 0, bottom-select, protect level [2:0], write-enable latch, busy}, MSB first. Protected regions are 64 KB-aligned slices of a 512 KB array, so only the top three address bits decide protection. Retained bits live in ordinary flip-flops that reset to zero.

Top module: `flash_guard`

## Requirements
- R1: After reset, status_o is 8'h00 and neither grant_o nor reject_o is high.
- R2: Request code 0 sets status bit 1 and code 1 clears it. Both are refused while busy or powered down.
- R3: A status write (code 2) is granted only when the write-enable latch is 1, the data is a single byte (req_extra low), and the lock is not engaged (lock engaged = status bit 7 is 1 and req_wp_n is 0). When granted, it loads bits 2–5 and bit 7 from req_data and ignores req_data bits 0, 1 and 6.
- R4: With protect level L = status bits 4:2 and bottom-select T = bit 5: L=0 protects nothing, L≥4 protects everything, and L=1, 2, 3 protect 64 KB, 128 KB and 256 KB respectively. The region sits at the highest addresses when T=0 and at the lowest when T=1.
- R5: Small-sector erase (code 3), sector erase (code 4) and program (code 6) are refused when the address is protected or the latch is 0. A refused request leaves the latch unchanged.
- R6: Chip erase (code 5) is granted only when the latch is 1 and the protect level is 0.
- R7: A granted status write, erase or program sets status bit 0 for exactly its parameter number of cycles. In the cycle bit 0 falls, bit 1 falls with it.
- R8: Any request other than wake that arrives while busy is refused, and status bits 7:2 do not change.
- R9: Power-down (code 7) is refused while busy. While powered down (pdown_o=1), every request except wake (code 8) is refused. Wake always succeeds and clears pdown_o. Codes 9–15 are always refused.
- R10: For each cycle in which req_valid is high, exactly one of grant_o or reject_o pulses in the next cycle. Neither pulses otherwise.
- R11: Status bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 4 | Request code (0..8, see requirements) |
| req_addr | input | ADDR_W | Byte address for erase and program |
| req_data | input | 8 | Data byte for status write |
| req_extra | input | 1 | Status write carried more than one data byte |
| req_wp_n | input | 1 | Level of the write-protect pin (low = lock may engage) |
| status_o | output | 8 | Status word |
| grant_o | output | 1 | Previous-cycle request accepted |
| reject_o | output | 1 | Previous-cycle request refused |
| pdown_o | output | 1 | Power-down state |

## Verification
A request sampled on a rising edge shows its outcome on grant_o, reject_o, status_o and pdown_o right after that same edge, so every result is due one clock after it is driven. The busy bit drops, and the latch with it, exactly the configured number of edges after the granting edge. The bench drives inputs on falling edges and advances its own model at each rising edge. It compares all outputs on the next falling edge, so each check lands in the cycle the result becomes due.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [3:0] {
    OP_WREN  = 4'd0,
    OP_WRDI  = 4'd1,
    OP_WRSR  = 4'd2,
    OP_SSE   = 4'd3,
    OP_SE    = 4'd4,
    OP_CE    = 4'd5,
    OP_PROG  = 4'd6,
    OP_PDOWN = 4'd7,
    OP_WAKE  = 4'd8
  } op_e;

  localparam int unsigned NUM_SLICES = 8;

  // Number of protected 64 KB slices for a protect level.
  function automatic logic [3:0] slice_count(input logic [2:0] lvl);
    logic [3:0] n;
    if (lvl == 3'd0)      n = 4'd0;
    else if (lvl[2])      n = 4'(NUM_SLICES);
    else                  n = 4'd1 << (lvl[1:0] - 2'd1);
    return n;
  endfunction

  // True when a slice index falls in the protected region.
  function automatic logic slice_hit(input logic [2:0] slice,
                                     input logic [2:0] lvl,
                                     input logic       bottom);
    logic [3:0] n;
    logic       hit;
    n = slice_count(lvl);
    if (bottom) hit = ({1'b0, slice} < n);
    else        hit = ({1'b0, slice} >= (4'(NUM_SLICES) - n));
    return hit;
  endfunction

  // Operations that start a self-timed cycle.
  function automatic logic is_timed(input logic [3:0] op);
    return (op == OP_WRSR) || (op == OP_SSE) || (op == OP_SE) ||
           (op == OP_CE)   || (op == OP_PROG);
  endfunction

  function automatic logic is_addressed(input logic [3:0] op);
    return (op == OP_SSE) || (op == OP_SE) || (op == OP_PROG);
  endfunction

endpackage

// File: rtl/flash_guard_prot.sv
module flash_guard_prot
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        lvl,
  input  logic              bottom,
  output logic              addr_hit,
  output logic              any_prot
);
  localparam int unsigned SLICE_MSB = ADDR_W - 1;

  logic [2:0] slice;
  logic       low_addr_unused;

  assign slice           = addr[SLICE_MSB -: 3];
  assign low_addr_unused = ^addr[SLICE_MSB-3:0];
  assign addr_hit        = slice_hit(slice, lvl, bottom);
  assign any_prot        = (slice_count(lvl) != 4'd0);

endmodule

// File: rtl/flash_guard_timer.sv
module flash_guard_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= load;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (done) busy <= 1'b0;
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R7
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (load != '0));

endmodule

// File: rtl/flash_guard_arb.sv
module flash_guard_arb
  import flash_guard_pkg::*;
(
  input  logic [3:0] op,
  input  logic       busy,
  input  logic       wel,
  input  logic       pdown,
  input  logic       lock_bit,
  input  logic       wp_n,
  input  logic       extra,
  input  logic       addr_hit,
  input  logic       any_prot,
  output logic       accept
);
  logic locked;
  assign locked = lock_bit && !wp_n;

  always_comb begin
    accept = 1'b0;
    if (pdown) begin
      accept = (op == OP_WAKE);
    end else if (op == OP_WAKE) begin
      accept = 1'b1;
    end else if (!busy) begin
      case (op)
        OP_WREN, OP_WRDI, OP_PDOWN: accept = 1'b1;
        OP_WRSR:                    accept = wel && !locked && !extra;
        OP_SSE, OP_SE, OP_PROG:     accept = wel && !addr_hit;
        OP_CE:                      accept = wel && !any_prot;
        default:                    accept = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned WRSR_CYC = 20,
  parameter int unsigned SSE_CYC  = 40,
  parameter int unsigned SE_CYC   = 80,
  parameter int unsigned CE_CYC   = 160,
  parameter int unsigned PROG_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_extra,
  input  logic              req_wp_n,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              pdown_o
);
  localparam int unsigned MAX_A   = (WRSR_CYC > SSE_CYC) ? WRSR_CYC : SSE_CYC;
  localparam int unsigned MAX_B   = (SE_CYC > CE_CYC) ? SE_CYC : CE_CYC;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC = (MAX_C > PROG_CYC) ? MAX_C : PROG_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             wel_q, tb_q, lock_q, pd_q, grant_q, reject_q;
  logic [2:0]       lvl_q;
  logic             busy, op_done, accept, addr_hit, any_prot, start;
  logic             take;
  logic [CNT_W-1:0] dur;
  logic             data_unused;

  assign data_unused = req_data[6] ^ req_data[1] ^ req_data[0];

  flash_guard_prot #(.ADDR_W(ADDR_W)) u_prot (
    .addr     (req_addr),
    .lvl      (lvl_q),
    .bottom   (tb_q),
    .addr_hit (addr_hit),
    .any_prot (any_prot)
  );

  flash_guard_arb u_arb (
    .op       (req_op),
    .busy     (busy),
    .wel      (wel_q),
    .pdown    (pd_q),
    .lock_bit (lock_q),
    .wp_n     (req_wp_n),
    .extra    (req_extra),
    .addr_hit (addr_hit),
    .any_prot (any_prot),
    .accept   (accept)
  );

  always_comb begin
    case (req_op)
      OP_WRSR: dur = CNT_W'(WRSR_CYC);
      OP_SSE:  dur = CNT_W'(SSE_CYC);
      OP_SE:   dur = CNT_W'(SE_CYC);
      OP_CE:   dur = CNT_W'(CE_CYC);
      default: dur = CNT_W'(PROG_CYC);
    endcase
  end

  assign take  = req_valid && accept;
  assign start = take && is_timed(req_op);

  flash_guard_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (dur),
    .busy  (busy),
    .done  (op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      lvl_q    <= 3'd0;
      tb_q     <= 1'b0;
      lock_q   <= 1'b0;
      pd_q     <= 1'b0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= take;
      reject_q <= req_valid && !accept;
      if (op_done) wel_q <= 1'b0;
      if (take) begin
        case (req_op)
          OP_WREN:  wel_q <= 1'b1;
          OP_WRDI:  wel_q <= 1'b0;
          OP_WRSR: begin
            lvl_q  <= req_data[4:2];
            tb_q   <= req_data[5];
            lock_q <= req_data[7];
          end
          OP_PDOWN: pd_q <= 1'b1;
          OP_WAKE:  pd_q <= 1'b0;
          default:  ;
        endcase
      end
    end
  end

  assign status_o = {lock_q, 1'b0, tb_q, lvl_q, wel_q, busy};
  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign pdown_o  = pd_q;

  // R10
  grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && reject_o));

  // R10
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant_o || reject_o));

  // R7
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WRSR && lock_q && !req_wp_n)
      |=> (reject_o && $stable(status_o[7:2])));

  // R5
  prot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_addressed(req_op) && addr_hit && !status_o[0])
      |=> (reject_o && $stable(status_o[1])));

  // R6
  chip_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_CE && lvl_q != 3'd0) |=> reject_o);

  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && status_o[0] && req_op != OP_WAKE)
      |=> (reject_o && $stable(status_o[7:2])));

  // R9
  pdown_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pd_q && req_op != OP_WAKE) |=> reject_o);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int AW = 19;
  localparam int D_WRSR = 20, D_SSE = 40, D_SE = 80, D_CE = 160, D_PROG = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          req_extra = 1'b0;
  logic          req_wp_n = 1'b1;
  logic [7:0]    status_o;
  logic          grant_o, reject_o, pdown_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model
  int m_left = 0;
  bit m_wel = 0, m_tb = 0, m_lock = 0, m_pd = 0;
  bit [2:0] m_lvl = 0;

  always #5 clk = ~clk;

  flash_guard #(.ADDR_W(AW), .WRSR_CYC(D_WRSR), .SSE_CYC(D_SSE), .SE_CYC(D_SE),
                .CE_CYC(D_CE), .PROG_CYC(D_PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_extra(req_extra),
    .req_wp_n(req_wp_n), .status_o(status_o), .grant_o(grant_o),
    .reject_o(reject_o), .pdown_o(pdown_o));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Byte-range form of the protected region.
  function automatic bit in_region(input int addr);
    int span;
    if (m_lvl == 0) return 0;
    if (m_lvl >= 4) return 1;
    span = 32'h80000 >> (4 - m_lvl);
    if (m_tb) return addr < span;
    return addr >= (32'h80000 - span);
  endfunction

  function automatic bit decide(input int op, input int addr, input bit extra, input bit wp);
    if (m_pd) return op == 8;
    if (op == 8) return 1;
    if (m_left > 0) return 0;
    if (op == 0 || op == 1 || op == 7) return 1;
    if (op == 2) return m_wel && !extra && !(m_lock && !wp);
    if (op == 3 || op == 4 || op == 6) return m_wel && !in_region(addr);
    if (op == 5) return m_wel && (m_lvl == 0);
    return 0;
  endfunction

  function automatic int exp_status();
    return {m_lock, 1'b0, m_tb, m_lvl, m_wel, (m_left > 0)};
  endfunction

  function automatic string tag_of(input int op);
    if (m_pd || op == 7 || op == 8 || op > 8) return "R9";
    if (m_left > 0) return "R8";
    case (op)
      0, 1: return "R2";
      2: return "R3";
      5: return "R6";
      default: return "R5";
    endcase
  endfunction

  // Drive at a falling edge, update model at the rising edge, check at the next falling edge.
  task automatic cycle(input bit v, input int op, input int addr, input int data,
                       input bit extra, input bit wp, input string tag);
    bit acc;
    req_valid = v; req_op = 4'(op); req_addr = AW'(addr);
    req_data = 8'(data); req_extra = extra; req_wp_n = wp;
    acc = v && decide(op, addr, extra, wp);
    @(posedge clk);
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_wel = 0;
    end
    if (acc) begin
      case (op)
        0: m_wel = 1;
        1: m_wel = 0;
        2: begin m_lvl = 3'(data >> 2); m_tb = data[5]; m_lock = data[7]; m_left = D_WRSR; end
        3: m_left = D_SSE;
        4: m_left = D_SE;
        5: m_left = D_CE;
        6: m_left = D_PROG;
        7: m_pd = 1;
        8: m_pd = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(grant_o == (v && acc), v ? "R10" : tag, "grant", grant_o, v && acc);
    chk(reject_o == (v && !acc), v ? "R10" : tag, "reject", reject_o, v && !acc);
    chk(status_o == 8'(exp_status()), (m_left > 0 || !v) ? "R7" : tag, "status",
        status_o, exp_status());
    chk(pdown_o == m_pd, "R9", "pdown", pdown_o, m_pd);
    chk(status_o[6] == 1'b0, "R11", "bit6", status_o[6], 0);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_left > 0) cycle(0, 0, 0, 0, 0, 1, "R7");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1
    chk(status_o == 8'h00, "R1", "reset status", status_o, 0);
    chk(!grant_o && !reject_o, "R1", "reset pulses", {grant_o, reject_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R1", "status after release", status_o, 0);

    // R3: status write without the latch is refused
    cycle(1, 2, 0, 8'hFF, 0, 1, "R3");
    // R2: latch set and clear
    cycle(1, 0, 0, 0, 0, 1, "R2");
    cycle(1, 1, 0, 0, 0, 1, "R2");
    cycle(1, 0, 0, 0, 0, 1, "R2");
    // R3: a multi-byte status write is refused and the latch is kept
    cycle(1, 2, 0, 8'h84, 1, 1, "R3");
    // R3: bits 0,1,6 of the data are ignored; R7 busy duration
    cycle(1, 2, 0, 8'hFF, 0, 1, "R3");
    drain();
    // R3: lock engaged with the pin low
    cycle(1, 0, 0, 0, 0, 0, "R2");
    cycle(1, 2, 0, 8'h00, 0, 0, "R3");
    // R6: chip erase refused while protected
    cycle(1, 5, 0, 0, 0, 0, "R6");
    // R3: the pin high releases the lock
    cycle(1, 2, 0, 8'h00, 0, 1, "R3");
    // R8: request while busy
    cycle(1, 0, 0, 0, 0, 1, "R8");
    cycle(1, 2, 0, 8'h0C, 0, 1, "R8");
    drain();
    // R9: power-down while busy is refused, then down/up
    cycle(1, 0, 0, 0, 0, 1, "R2");
    cycle(1, 5, 0, 0, 0, 1, "R6");
    cycle(1, 7, 0, 0, 0, 1, "R9");
    drain();
    cycle(1, 7, 0, 0, 0, 1, "R9");
    cycle(1, 0, 0, 0, 0, 1, "R9");
    cycle(1, 8, 0, 0, 0, 1, "R9");
    cycle(1, 9, 0, 0, 0, 1, "R9");

    // R4, R5: every level, both sides, every slice
    for (int t = 0; t < 2; t++) begin
      for (int l = 0; l < 8; l++) begin
        cycle(1, 0, 0, 0, 0, 1, "R4");
        cycle(1, 2, 0, (t << 5) | (l << 2), 0, 1, "R4");
        drain();
        for (int s = 0; s < 8; s++) begin
          cycle(1, 0, 0, 0, 0, 1, "R4");
          cycle(1, 6, (s << 16) | ($urandom & 16'hFFFF), 0, 0, 1, "R4");
          drain();
        end
      end
    end
    cycle(1, 0, 0, 0, 0, 1, "R3");
    cycle(1, 2, 0, 0, 0, 1, "R3");
    drain();

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int op;
      bit v;
      v = ($urandom % 4) != 0;
      op = ($urandom % 3 == 0) ? 0 : int'($urandom % 10);
      cycle(v, op, int'($urandom % 32'h80000), int'($urandom % 256),
            ($urandom % 8) == 0, ($urandom % 2) == 0, tag_of(op));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule